// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This block sits beside the storage of a dual-clock FIFO and turns the fill level into two active-low warning flags: an almost-full flag on the write side and an almost-empty flag on the read side. Each threshold is an offset held in a register. The FIFO supplies its fill level twice: once as seen from the write clock domain and once as seen from the read clock domain. The offsets are written through an 18-bit parallel bus in a fixed order and can be read back over an 18-bit output bus in the same order.

Two modes are captured while the master reset is high. The parity-placement mode decides which two bus bits are parity bits and are skipped when an offset is written. The flag-timing mode picks one of two schemes. In the single-edge scheme each flag is updated only by the clock of its own side. In the split-edge scheme a flag is raised by one clock and lowered by the other. The almost-full flag is then asserted on the write clock and released on the read clock. The almost-empty flag is asserted on the read clock and released on the write clock. The parity mode never touches the FIFO data itself. It only changes how offsets are written and read back.

Top module: `almostFlagUnit`

## Requirements
- R1: While `mrst` is high, both offsets take their defaults (7 each), `paeN` goes low, `pafN` goes high, `ofsQ` clears to zero, and both the load pointer and the readback pointer return to the empty offset.
- R2: In single-edge mode (`flagModePin` high at reset), `pafN` is updated only on `wClk`. It is low exactly when `wrCount` plus the full offset is at least DEPTH (default 1024).
- R3: In single-edge mode, `paeN` is updated only on `rClk`. It is low exactly when `rdCount` is less than or equal to the empty offset.
- R4: In split-edge mode (`flagModePin` low at reset), `pafN` goes low on a `wClk` edge when `wrCount` plus the full offset is at least DEPTH. It returns high only on an `rClk` edge when `rdCount` plus the full offset is below DEPTH.
- R5: In split-edge mode, `paeN` goes low on an `rClk` edge when `rdCount` is less than or equal to the empty offset. It returns high only on a `wClk` edge when `wrCount` is greater than the empty offset.
- R6: Offset writes (`ofsWr` on `wClk`) alternate between the two registers, starting with the empty offset and then the full offset. The pointer wraps back to the empty offset after the full one. A new offset is used from the next flag evaluation on.
- R7: With `parityModePin` high at reset (interleaved parity), bits 17 and 8 of `ofsD` are ignored. The written offset is {ofsD[16:9], ofsD[7:0]}.
- R8: With `parityModePin` low at reset (upper parity), bits 17 and 16 of `ofsD` are ignored. The written offset is ofsD[15:0].
- R9: Each `rClk` edge with `ofsRd` high loads `ofsQ` with the next offset: the empty offset first, then the full offset, alternating. In interleaved mode `ofsQ` = {0, ofs[15:8], 0, ofs[7:0]}, with bit 8 not carrying data. In upper-parity mode `ofsQ` = {2'b00, ofs[15:0]}.
- R10: `parityModePin` and `flagModePin` are sampled only while `mrst` is high. Changing them afterwards has no effect on flag timing or on offset packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write-side clock |
| rClk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, sampled on both clocks |
| parityModePin | input | 1 | 1 = interleaved parity (bits 17, 8), 0 = upper parity (bits 17, 16); latched at reset |
| flagModePin | input | 1 | 1 = single-edge flag timing, 0 = split-edge; latched at reset |
| wrCount | input | CNT_W | Fill level as seen in the write domain |
| rdCount | input | CNT_W | Fill level as seen in the read domain |
| ofsWr | input | 1 | Offset write strobe (wClk) |
| ofsRd | input | 1 | Offset readback strobe (rClk) |
| ofsD | input | 18 | Offset write data |
| pafN | output | 1 | Almost-full flag, active low |
| paeN | output | 1 | Almost-empty flag, active low |
| ofsQ | output | 18 | Offset readback data |

## Verification
The flags are first driven with equal write-side and read-side counts that sweep across each threshold at exactly the boundary value and one step away from it. This shows whether the comparisons are off by one. The two counts are then moved apart on purpose, which is the only way to tell the two timing schemes apart. A single-edge flag follows its own side's count, while a split-edge flag holds until the opposite side's count permits release. Offset writes use bus words whose parity bits are set and whose data bits differ in bit 8, so a wrong field mapping or a swapped write order changes both the readback word and the flag thresholds. The mode pins are also toggled after reset to show that they are ignored.

// File: rtl/almostFlagPkg.sv
package almostFlagPkg;
  localparam int BUS_W = 18;
  localparam int OFS_W = 16;

  typedef struct packed {
    logic ldEmpty;
    logic ldFull;
    logic rdEmpty;
    logic rdFull;
  } ofsStrobe_t;
endpackage

// File: rtl/almostFlagCtrl.sv
module almostFlagCtrl
  import almostFlagPkg::*;
(
  input  logic       wClk,
  input  logic       rClk,
  input  logic       mrst,
  input  logic       parityModePin,
  input  logic       flagModePin,
  input  logic       ofsWr,
  input  logic       ofsRd,
  output ofsStrobe_t strobe,
  output logic       interleaveW,
  output logic       interleaveR,
  output logic       syncW,
  output logic       syncR
);
  logic ldPtr;
  logic rdPtr;

  // write-domain copy of the modes and the load pointer
  always_ff @(posedge wClk) begin
    if (mrst) begin
      interleaveW <= parityModePin;
      syncW       <= flagModePin;
      ldPtr       <= 1'b0;
    end else if (ofsWr) begin
      ldPtr <= ~ldPtr;
    end
  end

  // read-domain copy of the modes and the readback pointer
  always_ff @(posedge rClk) begin
    if (mrst) begin
      interleaveR <= parityModePin;
      syncR       <= flagModePin;
      rdPtr       <= 1'b0;
    end else if (ofsRd) begin
      rdPtr <= ~rdPtr;
    end
  end

  always_comb begin
    strobe.ldEmpty = ofsWr & ~ldPtr & ~mrst;
    strobe.ldFull  = ofsWr &  ldPtr & ~mrst;
    strobe.rdEmpty = ofsRd & ~rdPtr & ~mrst;
    strobe.rdFull  = ofsRd &  rdPtr & ~mrst;
  end
endmodule

// File: rtl/almostFlagDp.sv
module almostFlagDp
  import almostFlagPkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int CNT_W     = 11,
  parameter int DEF_EMPTY = 7,
  parameter int DEF_FULL  = 7
) (
  input  logic             wClk,
  input  logic             rClk,
  input  logic             mrst,
  input  ofsStrobe_t       strobe,
  input  logic             interleaveW,
  input  logic             interleaveR,
  input  logic             syncW,
  input  logic             syncR,
  input  logic [BUS_W-1:0] ofsD,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [CNT_W-1:0] rdCount,
  output logic             pafN,
  output logic             paeN,
  output logic [BUS_W-1:0] ofsQ,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs
);
  localparam int AW = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;
  localparam logic [AW-1:0] DEPTH_X = AW'(DEPTH);

  logic [OFS_W-1:0] loadVal;
  logic [OFS_W-1:0] readSel;
  logic [BUS_W-1:0] readWord;
  logic             unusedParity;
  logic [AW-1:0]    wcX, rcX, emptyX, fullX;
  logic             fullHitW, fullHitR, emptyHitW, emptyHitR;
  logic             pafSyncN, paeSyncN;
  logic             wMarkF, rMarkF, wMarkE, rMarkE;
  logic             pafAsyncLow, paeAsyncLow;

  assign unusedParity = ofsD[BUS_W-1];

  // bus field mapping for offset writes and readback
  always_comb begin
    if (interleaveW) loadVal = {ofsD[16:9], ofsD[7:0]};
    else             loadVal = ofsD[15:0];
  end

  assign readSel = strobe.rdFull ? fullOfs : emptyOfs;

  always_comb begin
    if (interleaveR) readWord = {1'b0, readSel[15:8], 1'b0, readSel[7:0]};
    else             readWord = {2'b00, readSel};
  end

  always_ff @(posedge wClk) begin
    if (mrst) begin
      emptyOfs <= OFS_W'(DEF_EMPTY);
      fullOfs  <= OFS_W'(DEF_FULL);
    end else begin
      if (strobe.ldEmpty) emptyOfs <= loadVal;
      if (strobe.ldFull)  fullOfs  <= loadVal;
    end
  end

  // threshold comparisons in a widened space, no subtraction
  assign wcX    = AW'(wrCount);
  assign rcX    = AW'(rdCount);
  assign emptyX = AW'(emptyOfs);
  assign fullX  = AW'(fullOfs);

  assign fullHitW  = (wcX + fullX) >= DEPTH_X;
  assign fullHitR  = (rcX + fullX) >= DEPTH_X;
  assign emptyHitW = wcX <= emptyX;
  assign emptyHitR = rcX <= emptyX;

  // split-edge flags: each side toggles its own mark, flag = marks differ
  assign pafAsyncLow = wMarkF ^ rMarkF;
  assign paeAsyncLow = wMarkE ^ rMarkE;

  always_ff @(posedge wClk) begin
    if (mrst) begin
      pafSyncN <= 1'b1;
      wMarkF   <= 1'b0;
      wMarkE   <= 1'b0;
    end else begin
      pafSyncN <= ~fullHitW;
      if (fullHitW && !pafAsyncLow)  wMarkF <= ~wMarkF;
      if (!emptyHitW && paeAsyncLow) wMarkE <= ~wMarkE;
    end
  end

  always_ff @(posedge rClk) begin
    if (mrst) begin
      paeSyncN <= 1'b0;
      rMarkF   <= 1'b0;
      rMarkE   <= 1'b1;
      ofsQ     <= '0;
    end else begin
      paeSyncN <= ~emptyHitR;
      if (emptyHitR && !paeAsyncLow) rMarkE <= ~rMarkE;
      if (!fullHitR && pafAsyncLow)  rMarkF <= ~rMarkF;
      if (strobe.rdEmpty || strobe.rdFull) ofsQ <= readWord;
    end
  end

  assign pafN = syncW ? pafSyncN : ~pafAsyncLow;
  assign paeN = syncR ? paeSyncN : ~paeAsyncLow;
endmodule

// File: rtl/almostFlagUnit.sv
module almostFlagUnit
  import almostFlagPkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int CNT_W     = $clog2(DEPTH + 1),
  parameter int DEF_EMPTY = 7,
  parameter int DEF_FULL  = 7
) (
  input  logic             wClk,
  input  logic             rClk,
  input  logic             mrst,
  input  logic             parityModePin,
  input  logic             flagModePin,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [CNT_W-1:0] rdCount,
  input  logic             ofsWr,
  input  logic             ofsRd,
  input  logic [17:0]      ofsD,
  output logic             pafN,
  output logic             paeN,
  output logic [17:0]      ofsQ
);
  ofsStrobe_t       strobe;
  logic             interleaveW, interleaveR, syncW, syncR;
  logic [OFS_W-1:0] emptyOfs, fullOfs;

  almostFlagCtrl i_ctrl (
    .wClk(wClk), .rClk(rClk), .mrst(mrst),
    .parityModePin(parityModePin), .flagModePin(flagModePin),
    .ofsWr(ofsWr), .ofsRd(ofsRd), .strobe(strobe),
    .interleaveW(interleaveW), .interleaveR(interleaveR),
    .syncW(syncW), .syncR(syncR)
  );

  almostFlagDp #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)
  ) i_dp (
    .wClk(wClk), .rClk(rClk), .mrst(mrst), .strobe(strobe),
    .interleaveW(interleaveW), .interleaveR(interleaveR),
    .syncW(syncW), .syncR(syncR), .ofsD(ofsD),
    .wrCount(wrCount), .rdCount(rdCount),
    .pafN(pafN), .paeN(paeN), .ofsQ(ofsQ),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );
endmodule

// File: rtl/almostFlagChk.sv
module almostFlagChk #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input logic             wClk,
  input logic             rClk,
  input logic             mrst,
  input logic             syncW,
  input logic             syncR,
  input logic             interleaveR,
  input logic [CNT_W-1:0] wrCount,
  input logic [CNT_W-1:0] rdCount,
  input logic [15:0]      emptyOfs,
  input logic [15:0]      fullOfs,
  input logic             pafN,
  input logic             paeN,
  input logic [17:0]      ofsQ
);
  AST_RESET_FLAGS: assert property (@(posedge wClk)
    (mrst && $past(mrst)) |=> pafN); // R1

  AST_SYNC_PAF_SET: assert property (@(posedge wClk) disable iff (mrst)
    (syncW && (32'(wrCount) + 32'(fullOfs) >= 32'(DEPTH))) |=> !pafN); // R2

  AST_SYNC_PAE_SET: assert property (@(posedge rClk) disable iff (mrst)
    (syncR && (32'(rdCount) <= 32'(emptyOfs))) |=> !paeN); // R3

  AST_INTERLEAVE_READBACK: assert property (@(posedge rClk) disable iff (mrst)
    interleaveR |-> (ofsQ[8] == 1'b0 && ofsQ[17] == 1'b0)); // R9

  AST_UPPER_READBACK: assert property (@(posedge rClk) disable iff (mrst)
    !interleaveR |-> (ofsQ[17:16] == 2'b00)); // R9
endmodule

bind almostFlagUnit almostFlagChk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_almostFlagUnit.sv
module test_almostFlagUnit;
  localparam int DEPTH = 1024;
  localparam int CNT_W = 11;

  logic wClk = 1'b0;
  logic rClk = 1'b0;
  logic mrst = 1'b1;
  logic parityModePin = 1'b0;
  logic flagModePin = 1'b1;
  logic [CNT_W-1:0] wrCount = '0;
  logic [CNT_W-1:0] rdCount = '0;
  logic ofsWr = 1'b0;
  logic ofsRd = 1'b0;
  logic [17:0] ofsD = '0;
  logic pafN, paeN;
  logic [17:0] ofsQ;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  int  mEmpty, mFull;
  bit  mInter, mSync, mLdP, mRdP, mPafLow, mPaeLow;
  logic [17:0] mQ;

  always #4 wClk = ~wClk;
  initial begin
    #2;
    forever #4 rClk = ~rClk;
  end

  almostFlagUnit #(.DEPTH(DEPTH)) i_almostFlagUnit (
    .wClk(wClk), .rClk(rClk), .mrst(mrst),
    .parityModePin(parityModePin), .flagModePin(flagModePin),
    .wrCount(wrCount), .rdCount(rdCount),
    .ofsWr(ofsWr), .ofsRd(ofsRd), .ofsD(ofsD),
    .pafN(pafN), .paeN(paeN), .ofsQ(ofsQ)
  );

  function automatic int busToOfs(input bit inter, input logic [17:0] d);
    if (inter) return int'({d[16:9], d[7:0]});
    return int'(d[15:0]);
  endfunction

  function automatic logic [17:0] ofsToBus(input bit inter, input int v);
    logic [15:0] o;
    o = v[15:0];
    if (inter) return {1'b0, o[15:8], 1'b0, o[7:0]};
    return {2'b00, o};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of both clocks; model follows the write edge, then the read edge
  task automatic cyc(input int wc, input int rc, input bit wr, input bit rd,
                     input logic [17:0] d, input string req);
    bit hitW, hitE;
    wrCount = CNT_W'(wc); rdCount = CNT_W'(rc);
    ofsWr = wr; ofsRd = rd; ofsD = d;
    @(posedge wClk);
    if (mrst) begin
      mInter = parityModePin; mSync = flagModePin;
      mEmpty = 7; mFull = 7; mLdP = 0; mRdP = 0;
      mPafLow = 0; mPaeLow = 1; mQ = '0;
    end else begin
      hitW = (wc + mFull) >= DEPTH;
      hitE = wc <= mEmpty;
      if (mSync) mPafLow = hitW;
      else begin
        if (hitW) mPafLow = 1;
        if (!hitE) mPaeLow = 0;
      end
      if (wr) begin
        if (!mLdP) mEmpty = busToOfs(mInter, d);
        else       mFull  = busToOfs(mInter, d);
        mLdP = !mLdP;
      end
    end
    @(posedge rClk);
    if (!mrst) begin
      hitW = (rc + mFull) >= DEPTH;
      hitE = rc <= mEmpty;
      if (mSync) mPaeLow = hitE;
      else begin
        if (hitE) mPaeLow = 1;
        if (!hitW) mPafLow = 0;
      end
      if (rd) begin
        mQ = ofsToBus(mInter, mRdP ? mFull : mEmpty);
        mRdP = !mRdP;
      end
    end
    #1;
    check(req, "pafN", int'(pafN), int'(!mPafLow));
    check(req, "paeN", int'(paeN), int'(!mPaeLow));
    check(req, "ofsQ", int'(ofsQ), int'(mQ));
  endtask

  task automatic doReset(input bit par, input bit flg);
    mrst = 1'b1; parityModePin = par; flagModePin = flg;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, '0, "R1");
    mrst = 1'b0;
  endtask

  initial begin
    // R1: reset state, upper parity, single-edge timing
    doReset(1'b0, 1'b1);
    cyc(0, 0, 0, 0, '0, "R1");
    cyc(0, 0, 0, 1, '0, "R1");   // readback starts at the empty default
    cyc(0, 0, 0, 1, '0, "R1");
    // R3 threshold edges with default empty offset 7
    cyc(0, 7, 0, 0, '0, "R3");
    cyc(0, 8, 0, 0, '0, "R3");
    cyc(900, 7, 0, 0, '0, "R3");  // write count irrelevant in single-edge mode
    // R2 threshold edges with default full offset 7
    cyc(1016, 8, 0, 0, '0, "R2");
    cyc(1017, 8, 0, 0, '0, "R2");
    cyc(1017, 0, 0, 0, '0, "R2");  // read count irrelevant
    cyc(1016, 1020, 0, 0, '0, "R2");
    // R10: pins move after reset, nothing changes
    parityModePin = 1'b1; flagModePin = 1'b0;
    cyc(1017, 500, 0, 0, '0, "R10");
    cyc(100, 1020, 0, 0, '0, "R10");
    cyc(100, 3, 0, 0, '0, "R10");
    cyc(100, 300, 0, 0, '0, "R10");
    // R6 / R8: load empty then full, parity bits set
    cyc(100, 300, 1, 0, 18'h3_0123, "R8");
    cyc(100, 300, 1, 0, 18'h2_0100, "R6");
    cyc(100, 291, 0, 0, '0, "R8");
    cyc(100, 292, 0, 0, '0, "R8");
    cyc(767, 292, 0, 0, '0, "R6");
    cyc(768, 292, 0, 0, '0, "R6");
    // R9 readback order with wrap, format from R10 (mode still upper parity)
    cyc(0, 500, 0, 1, '0, "R9");
    cyc(0, 500, 0, 1, '0, "R9");
    cyc(0, 500, 0, 1, '0, "R10");
    // R6: third write wraps to the empty offset
    cyc(0, 500, 1, 0, 18'h0_0010, "R6");
    cyc(0, 16, 0, 0, '0, "R6");
    cyc(0, 17, 0, 0, '0, "R6");

    // R7: interleaved parity, split-edge timing
    doReset(1'b1, 1'b0);
    cyc(0, 0, 0, 0, '0, "R1");
    cyc(0, 0, 1, 0, 18'h2_0155, "R7");
    cyc(0, 0, 1, 0, 18'h0_0540, "R7");
    cyc(0, 0, 0, 1, '0, "R9");
    cyc(0, 0, 0, 1, '0, "R9");
    // R5: read side past threshold does not release; write side does
    cyc(0, 100, 0, 0, '0, "R5");
    cyc(85, 100, 0, 0, '0, "R5");
    cyc(86, 100, 0, 0, '0, "R5");
    cyc(86, 85, 0, 0, '0, "R5");
    cyc(200, 300, 0, 0, '0, "R5");
    // R4: write sets, write drop alone does not release, read side does
    cyc(447, 600, 0, 0, '0, "R4");
    cyc(448, 600, 0, 0, '0, "R4");
    cyc(100, 600, 0, 0, '0, "R4");
    cyc(100, 448, 0, 0, '0, "R4");
    cyc(100, 447, 0, 0, '0, "R4");
    cyc(100, 447, 0, 0, '0, "R4");
    // R10: pins toggled after reset keep split-edge timing
    parityModePin = 1'b0; flagModePin = 1'b1;
    cyc(500, 600, 0, 0, '0, "R10");
    cyc(0, 600, 0, 0, '0, "R10");
    cyc(0, 600, 0, 1, '0, "R10");

    // R3 again after a reset back to single-edge, upper parity
    doReset(1'b0, 1'b1);
    cyc(0, 8, 0, 0, '0, "R3");
    cyc(0, 7, 0, 0, '0, "R3");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule